// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Row Refresh

This controller sits between a host and an asynchronous dynamic RAM whose address pins are shared between row and column. The host issues single-word reads and writes with a full address. The controller splits each address in two. It drives the upper half while lowering the active-low row strobe. It then drives the lower half while lowering the active-low column strobe. Write data and the write-enable go out before the column strobe falls. Read data is captured just before both strobes rise.

The stored charge leaks, so the controller also visits every row on a schedule. A timer divides the retention period, given in clocks, by the number of rows. Each time the timer expires, it marks one refresh as pending. A pending refresh runs as a row-strobe-only cycle on the next row in turn, with the column strobe and write-enable held high. Refresh wins against a new host request but never cuts a running cycle short. After reset the controller first refreshes every row once, and only then opens the host port.

The request side is valid/ready. The host holds `req_valid` and its payload steady until a cycle in which `req_ready` is high, and that cycle transfers the request. Only one request is in flight at a time. Read data returns as a single-cycle `rsp_valid` pulse with no ready, so the host must take it in that cycle. Writes produce no response.

Top module: `dram_ctrl`

## Requirements
- R1: The row half (`req_addr[2*ROW_W-1:ROW_W]`) is on `ram_addr` when `ram_ras_n` falls, and the column half (`req_addr[ROW_W-1:0]`) is on `ram_addr` when `ram_cas_n` falls.
- R2: `ram_cas_n` is low only while `ram_ras_n` is low, `ram_cas_n` is high when `ram_ras_n` falls, and both strobes rise together at the end of an access.
- R3: `ram_addr` is stable for at least T_SU clocks before each strobe falls. The row half stays on the pins for more than T_HOLD clocks of row-strobe low before it changes.
- R4: In a write, `ram_we_n` is low and `ram_dq_oe` is high with the write word on `ram_dq_out` when `ram_cas_n` falls, and the word is stored at the addressed location.
- R5: A read returns the word at its address on `rsp_data`, with `rsp_valid` high for exactly one clock.
- R6: A refresh lowers only `ram_ras_n`, presenting the refresh row. Successive refreshes visit rows 0, 1, …, 2^ROW_W−1 and then wrap to 0.
- R7: A refresh becomes pending every RET_CLKS/2^ROW_W clocks, so every row is refreshed again within RET_CLKS plus the length of one access cycle.
- R8: While a refresh is pending, `req_ready` is low. Refreshes keep their rate while the host requests back to back.
- R9: `ram_ras_n` stays high for at least T_PRE clocks between any two low periods.
- R10: After reset both strobes are high and the refresh row is 0. `req_ready` stays low until one refresh of every row has completed.
- R11: A request transfers only when `req_valid` and `req_ready` are both high, and `req_ready` is low for the rest of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*ROW_W | Full word address, row half on top |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | Read data valid, one-clock pulse |
| rsp_data | output | DATA_W | Read word |
| ram_addr | output | ROW_W | Multiplexed row/column address pins |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | 1 | Column strobe, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_dq_out | output | DATA_W | Data toward the memory |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_out` |
| ram_dq_in | input | DATA_W | Data from the memory |

## Verification
The assertions assume that the timing parameters are at least one and that the column-strobe width is no shorter than the row hold. They also assume that the refresh interval is longer than one full access, so at most one refresh is ever pending. The bench uses a small configuration whose parameters satisfy this. The bench keeps `req_valid` and its payload unchanged from the moment it raises them until the transfer cycle, and it never stalls a response. It models the memory so that read data is valid whenever the column strobe is low. This matches the controller's capture point at the end of the column-strobe window.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    S_IDLE,   // strobes high, precharge counting
    S_RSU,    // row on pins, RAS still high (setup)
    S_RHLD,   // RAS low, row held
    S_CSU,    // column on pins, CAS high (setup)
    S_CLO,    // CAS low
    S_RLO     // refresh: RAS low only
  } seq_state_t;
endpackage

// File: rtl/dram_refresh.sv
module dram_refresh #(
  parameter int ROW_W    = 4,
  parameter int RET_CLKS = 1600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_start,
  output logic             ref_pending,
  output logic [ROW_W-1:0] ref_row,
  output logic             init_done
);
  localparam int ROWS = 1 << ROW_W;
  localparam int REFI = RET_CLKS / ROWS;
  localparam int TW   = $clog2(REFI + 1);

  logic [TW-1:0] tmr;
  logic          pend;
  logic          tick;

  assign tick        = (tmr == TW'(REFI - 1));
  assign ref_pending = pend | ~init_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr       <= '0;
      pend      <= 1'b0;
      ref_row   <= '0;
      init_done <= 1'b0;
    end else begin
      tmr <= tick ? '0 : tmr + 1'b1;
      if (tick)           pend <= 1'b1;
      else if (ref_start) pend <= 1'b0;
      if (ref_start) begin
        ref_row <= ref_row + 1'b1;
        if (ref_row == {ROW_W{1'b1}}) init_done <= 1'b1;
      end
    end
  end

  // R6: refresh row steps by one and wraps
  a_r6_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    ref_start |=> ref_row == $past(ref_row) + 1'b1);

  // R7: interval expiry leaves a refresh pending
  a_r7_tick_pends: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ref_pending);
endmodule

// File: rtl/dram_seq.sv
module dram_seq import dram_pkg::*; #(
  parameter int ROW_W    = 4,
  parameter int DATA_W   = 8,
  parameter int T_PRE    = 2,
  parameter int T_SU     = 1,
  parameter int T_HOLD   = 1,
  parameter int T_STROBE = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [2*ROW_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  input  logic                ref_pending,
  input  logic [ROW_W-1:0]    ref_row,
  input  logic                init_done,
  output logic                ref_start,
  output logic [ROW_W-1:0]    ram_addr,
  output logic                ram_ras_n,
  output logic                ram_cas_n,
  output logic                ram_we_n,
  output logic [DATA_W-1:0]   ram_dq_out,
  output logic                ram_dq_oe,
  input  logic [DATA_W-1:0]   ram_dq_in
);
  localparam int CW = $clog2(T_PRE + T_SU + T_HOLD + T_STROBE + 2);

  seq_state_t        st;
  logic [CW-1:0]     cnt;
  logic [ROW_W-1:0]  row_q, col_q;
  logic              wr_q, refr_q, rv_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              pre_ok, last, col_phase, wr_phase;
  int                len;

  always_comb begin
    case (st)
      S_RSU, S_CSU: len = T_SU;
      S_RHLD:       len = T_HOLD;
      default:      len = T_STROBE;
    endcase
  end

  assign last      = (int'(cnt) == len - 1);
  assign pre_ok    = (st == S_IDLE) && (int'(cnt) >= T_PRE - 1);
  assign ref_start = pre_ok && ref_pending;
  assign req_ready = pre_ok && !ref_pending && init_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      row_q  <= '0;
      col_q  <= '0;
      wr_q   <= 1'b0;
      refr_q <= 1'b0;
      wd_q   <= '0;
      rd_q   <= '0;
      rv_q   <= 1'b0;
    end else begin
      rv_q <= 1'b0;
      if (st == S_IDLE) begin
        if (!pre_ok) cnt <= cnt + 1'b1;
        if (ref_start) begin
          row_q  <= ref_row;
          refr_q <= 1'b1;
          wr_q   <= 1'b0;
          cnt    <= '0;
          st     <= S_RSU;
        end else if (req_valid && req_ready) begin
          row_q  <= req_addr[2*ROW_W-1:ROW_W];
          col_q  <= req_addr[ROW_W-1:0];
          wr_q   <= req_write;
          wd_q   <= req_wdata;
          refr_q <= 1'b0;
          cnt    <= '0;
          st     <= S_RSU;
        end
      end else if (!last) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          S_RSU:  st <= refr_q ? S_RLO : S_RHLD;
          S_RHLD: st <= S_CSU;
          S_CSU:  st <= S_CLO;
          S_CLO: begin
            if (!wr_q) begin
              rd_q <= ram_dq_in;
              rv_q <= 1'b1;
            end
            st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign col_phase  = (st == S_CSU) || (st == S_CLO);
  assign wr_phase   = col_phase && wr_q;
  assign ram_addr   = col_phase ? col_q : row_q;
  assign ram_ras_n  = (st == S_IDLE) || (st == S_RSU);
  assign ram_cas_n  = (st != S_CLO);
  assign ram_we_n   = !wr_phase;
  assign ram_dq_oe  = wr_phase;
  assign ram_dq_out = wd_q;
  assign rsp_valid  = rv_q;
  assign rsp_data   = rd_q;

  // high-time run of RAS for the precharge check
  logic [CW-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (!rst_n)                         hi_run <= '0;
    else if (!ram_ras_n)                hi_run <= '0;
    else if (hi_run != {CW{1'b1}})      hi_run <= hi_run + 1'b1;
  end

  // R9: RAS precharge honoured before every fall
  a_r9_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_ras_n) |-> int'(hi_run) >= T_PRE);

  // R2: CAS only inside RAS
  a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cas_n |-> !ram_ras_n);

  // R3: row address unchanged across the RAS edge
  a_r3_row_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_ras_n) |-> $stable(ram_addr));

  // R3: column address unchanged across the CAS edge
  a_r3_col_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_cas_n) |-> $stable(ram_addr));

  // R4: write data driven while CAS is low in a write
  a_r4_data_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cas_n && !ram_we_n) |-> ram_dq_oe);

  // R5: read response is a single pulse
  a_r5_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R11: no second transfer right after one
  a_r11_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int ROW_W    = 4,
  parameter int DATA_W   = 8,
  parameter int RET_CLKS = 1600,
  parameter int T_PRE    = 2,
  parameter int T_SU     = 1,
  parameter int T_HOLD   = 1,
  parameter int T_STROBE = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [2*ROW_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic [ROW_W-1:0]    ram_addr,
  output logic                ram_ras_n,
  output logic                ram_cas_n,
  output logic                ram_we_n,
  output logic [DATA_W-1:0]   ram_dq_out,
  output logic                ram_dq_oe,
  input  logic [DATA_W-1:0]   ram_dq_in
);
  logic             ref_start, ref_pending, init_done;
  logic [ROW_W-1:0] ref_row;

  dram_refresh #(.ROW_W(ROW_W), .RET_CLKS(RET_CLKS)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_start(ref_start),
    .ref_pending(ref_pending), .ref_row(ref_row), .init_done(init_done)
  );

  dram_seq #(
    .ROW_W(ROW_W), .DATA_W(DATA_W), .T_PRE(T_PRE), .T_SU(T_SU),
    .T_HOLD(T_HOLD), .T_STROBE(T_STROBE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ref_pending(ref_pending), .ref_row(ref_row), .init_done(init_done),
    .ref_start(ref_start),
    .ram_addr(ram_addr), .ram_ras_n(ram_ras_n), .ram_cas_n(ram_cas_n),
    .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
    .ram_dq_in(ram_dq_in)
  );

  // R8: a pending refresh closes the host port
  a_r8_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pending |-> !req_ready);

  // R10: host port closed until the first full pass
  a_r10_init_gate: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> init_done);
endmodule

// File: tb/dram_ctrl_test.sv
module dram_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 4, DATA_W = 8, RET_CLKS = 1600;
  localparam int T_PRE = 2, T_SU = 1, T_HOLD = 1, T_STROBE = 2;
  localparam int ROWS = 1 << ROW_W;
  localparam int AW = 2 * ROW_W;
  localparam int WORDS = 1 << AW;
  localparam int REFI = RET_CLKS / ROWS;
  localparam int SLACK = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, ram_ras_n, ram_cas_n, ram_we_n, ram_dq_oe;
  logic [DATA_W-1:0] rsp_data, ram_dq_out, ram_dq_in;
  logic [ROW_W-1:0] ram_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_ctrl #(.ROW_W(ROW_W), .DATA_W(DATA_W), .RET_CLKS(RET_CLKS), .T_PRE(T_PRE),
              .T_SU(T_SU), .T_HOLD(T_HOLD), .T_STROBE(T_STROBE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ram_addr(ram_addr),
    .ram_ras_n(ram_ras_n), .ram_cas_n(ram_cas_n), .ram_we_n(ram_we_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in));

  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int a, input int pass);
    return DATA_W'((a * 37 + 11) ^ (pass * 8'hA5));
  endfunction

  // memory model
  logic [DATA_W-1:0] mem [WORDS];
  logic [ROW_W-1:0] row_l = '0;
  assign ram_dq_in = !ram_cas_n ? mem[{row_l, ram_addr}] : '0;

  int cyc = 0, stab = 0, ras_hi = 0, ras_lo = 0, ref_count = 0, exp_ref = 0;
  int last_ref [ROWS];
  bit seen [ROWS];
  bit prev_ras = 1'b1, prev_cas = 1'b1, saw_cas = 1'b0;
  logic [ROW_W-1:0] prev_addr = '0;
  logic [AW-1:0] cur_addr = '0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      stab = (ram_addr == prev_addr) ? stab + 1 : 0;
      if (req_ready && ref_count < ROWS) chk(1'b0, "R10 ready before initial pass", ref_count, ROWS);
      if (!ram_cas_n && ram_ras_n) chk(1'b0, "R2 CAS low outside RAS", 1, 0);
      if (prev_ras && !ram_ras_n) begin
        chk(ras_hi >= T_PRE, "R9 precharge", ras_hi, T_PRE);
        chk(stab >= T_SU, "R3 row setup", stab, T_SU);
        chk(ram_cas_n, "R2 CAS high at RAS fall", int'(ram_cas_n), 1);
        row_l = ram_addr;
        saw_cas = 1'b0;
        if (seen[ram_addr])
          chk(cyc - last_ref[ram_addr] <= RET_CLKS + SLACK, "R7 row revisit gap",
              cyc - last_ref[ram_addr], RET_CLKS + SLACK);
        last_ref[ram_addr] = cyc;
        seen[ram_addr] = 1'b1;
        ras_lo = 1;
      end else if (!prev_ras && ram_ras_n) begin
        chk(ram_cas_n, "R2 strobes rise together", int'(ram_cas_n), 1);
        if (saw_cas) chk(prev_cas == 1'b0, "R2 CAS held to end", int'(prev_cas), 0);
        if (!saw_cas) begin
          chk(int'(row_l) == exp_ref, "R6 refresh row order", int'(row_l), exp_ref);
          exp_ref = (exp_ref + 1) % ROWS;
          ref_count++;
        end
        ras_hi = 1;
      end else if (!ram_ras_n) begin
        ras_lo++;
        if (ram_cas_n && !saw_cas && ram_addr != prev_addr)
          chk(ras_lo > T_HOLD, "R3 row hold", ras_lo, T_HOLD + 1);
      end else ras_hi++;
      if (prev_cas && !ram_cas_n) begin
        saw_cas = 1'b1;
        chk(stab >= T_SU, "R3 column setup", stab, T_SU);
        chk({row_l, ram_addr} == cur_addr, "R1 row/column split", int'({row_l, ram_addr}), int'(cur_addr));
        if (!ram_we_n) begin
          chk(ram_dq_oe, "R4 data driven", int'(ram_dq_oe), 1);
          mem[{row_l, ram_addr}] = ram_dq_out;
        end
      end
      if (!ram_ras_n && saw_cas == 1'b0 && !ram_we_n && ram_cas_n && prev_ras == 1'b0 && ras_lo > T_STROBE + T_HOLD)
        chk(1'b0, "R6 WE low in refresh", 0, 1);
      prev_ras = ram_ras_n;
      prev_cas = ram_cas_n;
      prev_addr = ram_addr;
    end
  end

  task automatic do_req(input bit wr, input int a, input logic [DATA_W-1:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    cur_addr = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R11 ready low during access", int'(req_ready), 0);
  endtask

  task automatic do_read(input int a, input logic [DATA_W-1:0] exp);
    int n = 0;
    do_req(1'b0, a, '0);
    while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
    chk(rsp_data == exp, "R5 read data", int'(rsp_data), int'(exp));
    @(negedge clk);
    chk(!rsp_valid, "R5 single-cycle response", int'(rsp_valid), 0);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    int r0, c0;
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(ram_ras_n && ram_cas_n, "R10 strobes high in reset", int'({ram_ras_n, ram_cas_n}), 3);
    chk(!req_ready, "R10 ready low in reset", int'(req_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ram_addr == '0, "R10 first refresh row is zero", int'(ram_addr), 0);
    while (!req_ready) @(negedge clk);
    chk(ref_count >= ROWS, "R10 initial pass complete", ref_count, ROWS);
    r0 = ref_count; c0 = cyc;
    for (int a = 0; a < WORDS; a++) do_req(1'b1, a, pat(a, 0));
    for (int a = 0; a < WORDS; a++) do_read(a, pat(a, 0));
    for (int a = WORDS - 1; a >= 0; a--) begin
      do_req(1'b1, a, pat(a, 1));
      do_read(a, pat(a, 1));
    end
    for (int a = 0; a < WORDS; a += 17) do_read(a, pat(a, 1));
    chk(ref_count - r0 >= (cyc - c0) / REFI - 1, "R8 refresh rate under load",
        ref_count - r0, (cyc - c0) / REFI - 1);
    chk(ref_count > ROWS, "R6 refresh counter wrapped", ref_count, ROWS + 1);
    for (int r = 0; r < ROWS; r++)
      chk(seen[r] && (cyc - last_ref[r] <= RET_CLKS + SLACK), "R7 final coverage",
          cyc - last_ref[r], RET_CLKS + SLACK);
    done = 1'b1;
    summary();
  end
endmodule